// File: doc/BRIEF.md
# Slave Address Bit Arbiter

This block is the slave-side engine that resolves contention among request-capable slaves once a slave arbitration phase has been entered on a two-wire serial control bus. Each slave that competes places its own slave address on the shared data line, one bit per bus clock, starting with the most significant bit. It reads the line back on every falling clock edge. The line behaves as wired-OR with a bus keeper. A slave drives the line only when its own bit is 1, and it leaves the line undriven when its bit is 0.

When a slave reads a value that differs from its own bit, it withdraws. It releases its driver and stays silent for the rest of the phase. After the last address bit, only the slave with the highest address is still in. That slave raises its won flag, and every other slave raises its lost flag. The winner then drives the following command frame, while the bus owner keeps driving the clock. That step is handled outside this block.

All state changes on the falling edge of the bus clock. A one-cycle start pulse, sampled on a falling edge, opens a new arbitration. On that same edge the block latches the participate flag and the address.

Top module: `slv_addr_arb`

## Requirements
- R1: While rst_ni is low, sdata_oe_o, won_o and lost_o are all 0.
- R2: On the falling edge where start_i=1 and part_i=1, the block latches addr_i. Right after that edge, sdata_oe_o equals address bit 3. Later changes on addr_i have no effect until the next start.
- R3: At each of the next falling edges, the block compares sdata_i with the current address bit, going from bit 3 down to bit 0. After a match on bit k>0, sdata_oe_o equals bit k-1.
- R4: A mismatch on any compared bit sets lost_o after that edge. sdata_oe_o then stays 0 for the rest of the arbitration.
- R5: If all four bits match, won_o is set after the fourth falling edge that follows the start edge. won_o and lost_o are never 1 together.
- R6: On a start edge with part_i=0, lost_o is set right after that edge and sdata_oe_o stays 0.
- R7: won_o and lost_o hold their values until the next start pulse, which begins a fresh arbitration from either state.
- R8: sdata_o is 1 whenever sdata_oe_o is 1, so only 1s are driven. Against a competitor on the wired-OR line, the higher address wins. Equal addresses both see a win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; state changes on the falling edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins arbitration |
| part_i | input | 1 | This slave competes when 1 |
| addr_i | input | 4 | Own slave address |
| sdata_i | input | 1 | Data line as read back from the bus |
| sdata_o | output | 1 | Data value driven onto the line |
| sdata_oe_o | output | 1 | Driver enable for sdata_o |
| won_o | output | 1 | Arbitration won |
| lost_o | output | 1 | Arbitration lost or not entered |

## Verification
A wrong bit index or a wrong shift of the latched address shows up at the ports as a wrong sdata_oe_o value within one bus clock of the falling edge where it happens. The reason is that the enable mirrors the current address bit on every cycle of the arbitration. A compare or state fault shows up as a wrong won_o or lost_o value no later than the fourth falling edge after start. A driver that does not release after a loss shows up as a high sdata_oe_o while lost_o is set. The bench models a competitor on the wired-OR line and predicts, cycle by cycle, the enable and both flags for ties, for losses at the top bit, at the bottom bit and in between, and for the case where the slave does not participate.

// File: rtl/slv_arb_pkg.sv
package slv_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WON  = 2'd2,
    ST_LOST = 2'd3
  } arb_st_e;
endpackage

// File: rtl/arb_bit_sel.sv
module arb_bit_sel #(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              cur_bit_o,
  output logic              last_bit_o
);
  localparam int IDX_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(ADDR_W - 1);

  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
      idx_q  <= IDX_TOP;
    end else if (step_i) begin
      idx_q  <= idx_q - 1'b1;
    end
  end

  assign cur_bit_o  = addr_q[idx_q];
  assign last_bit_o = (idx_q == '0);

  AST_IDX_IN_RANGE: assert property (@(negedge clk_i) disable iff (!rst_ni)
    int'(idx_q) < ADDR_W); // R3
  AST_STEP_DOWN: assert property (@(negedge clk_i) disable iff (!rst_ni)
    step_i && !load_i |=> idx_q == $past(idx_q) - 1'b1); // R3
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import slv_arb_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    part_i,
  input  logic    sdata_i,
  input  logic    cur_bit_i,
  input  logic    last_bit_i,
  output logic    load_o,
  output logic    step_o,
  output arb_st_e state_o
);
  arb_st_e state_q, state_d;
  logic    match;

  assign match  = (sdata_i == cur_bit_i);
  assign load_o = start_i & part_i;
  assign step_o = (state_q == ST_RUN) & ~start_i & match & ~last_bit_i;

  always_comb begin
    state_d = state_q;
    if (start_i) begin
      state_d = part_i ? ST_RUN : ST_LOST;
    end else if (state_q == ST_RUN) begin
      if (!match)          state_d = ST_LOST;
      else if (last_bit_i) state_d = ST_WON;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  AST_MISMATCH_DROP: assert property (@(negedge clk_i) disable iff (!rst_ni)
    state_q == ST_RUN && !start_i && sdata_i != cur_bit_i |=> state_q == ST_LOST); // R4
  AST_LAST_MATCH_WIN: assert property (@(negedge clk_i) disable iff (!rst_ni)
    state_q == ST_RUN && !start_i && last_bit_i && sdata_i == cur_bit_i |=> state_q == ST_WON); // R5
  AST_START_ENTERS: assert property (@(negedge clk_i) disable iff (!rst_ni)
    start_i && part_i |=> state_q == ST_RUN); // R2
endmodule

// File: rtl/arb_drive.sv
module arb_drive
  import slv_arb_pkg::*;
(
  input  arb_st_e state_i,
  input  logic    cur_bit_i,
  output logic    sdata_o,
  output logic    sdata_oe_o,
  output logic    won_o,
  output logic    lost_o
);
  // wired-OR line: only 1s are driven, 0s leave the line to the keeper
  assign sdata_oe_o = (state_i == ST_RUN) & cur_bit_i;
  assign sdata_o    = sdata_oe_o;
  assign won_o      = (state_i == ST_WON);
  assign lost_o     = (state_i == ST_LOST);
endmodule

// File: rtl/slv_addr_arb.sv
module slv_addr_arb
  import slv_arb_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              part_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sdata_i,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic              won_o,
  output logic              lost_o
);
  logic    load, step, cur_bit, last_bit;
  arb_st_e state;

  arb_bit_sel #(.ADDR_W(ADDR_W)) u_bit_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .step_i     (step),
    .addr_i     (addr_i),
    .cur_bit_o  (cur_bit),
    .last_bit_o (last_bit)
  );

  arb_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .part_i     (part_i),
    .sdata_i    (sdata_i),
    .cur_bit_i  (cur_bit),
    .last_bit_i (last_bit),
    .load_o     (load),
    .step_o     (step),
    .state_o    (state)
  );

  arb_drive u_drive (
    .state_i    (state),
    .cur_bit_i  (cur_bit),
    .sdata_o    (sdata_o),
    .sdata_oe_o (sdata_oe_o),
    .won_o      (won_o),
    .lost_o     (lost_o)
  );

  AST_FLAGS_EXCL: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !(won_o && lost_o)); // R5
  AST_SILENT_WHEN_DONE: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (won_o || lost_o) |-> !sdata_oe_o); // R4
  AST_LOST_HOLD: assert property (@(negedge clk_i) disable iff (!rst_ni)
    lost_o && !start_i |=> lost_o); // R7
  AST_WON_HOLD: assert property (@(negedge clk_i) disable iff (!rst_ni)
    won_o && !start_i |=> won_o); // R7
  AST_NO_PART_LOST: assert property (@(negedge clk_i) disable iff (!rst_ni)
    start_i && !part_i |=> lost_o && !sdata_oe_o); // R6
  AST_DRIVE_ONES: assert property (@(negedge clk_i) disable iff (!rst_ni)
    sdata_oe_o |-> sdata_o); // R8
endmodule

// File: tb/sim_slv_addr_arb.sv
module sim_slv_addr_arb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       part = 1'b0;
  logic [3:0] addr = 4'h0;
  logic       comp_drv = 1'b0;
  logic       sdata_o, sdata_oe, won, lost;
  logic       line;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit drv_done = 1'b0;

  typedef struct {
    logic  oe;
    logic  won;
    logic  lost;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;  // 50 MHz

  assign line = (sdata_oe & sdata_o) | comp_drv;

  slv_addr_arb u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .part_i     (part),
    .addr_i     (addr),
    .sdata_i    (line),
    .sdata_o    (sdata_o),
    .sdata_oe_o (sdata_oe),
    .won_o      (won),
    .lost_o     (lost)
  );

  task automatic push(input logic oe, input logic w, input logic l, input string tag);
    exp_t e;
    e.oe = oe; e.won = w; e.lost = l; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Model of this slave plus one competitor on the wired-OR line
  task automatic arb_run(input logic [3:0] a, input logic p, input logic c_on,
                         input logic [3:0] c, input string tag);
    logic me_in, c_in, ln;
    @(posedge clk);
    start = 1'b1; part = p; addr = a; comp_drv = 1'b0;
    push(p & a[3], 1'b0, ~p, {tag, " start R2 R6"});
    me_in = p; c_in = c_on;
    for (int i = 3; i >= 0; i--) begin
      @(posedge clk);
      start = 1'b0; addr = ~a;  // latched value must be used (R2)
      comp_drv = c_in & c[i];
      ln = (me_in & a[i]) | comp_drv;
      if (me_in && ln != a[i]) me_in = 1'b0;
      if (c_in && ln != c[i]) c_in = 1'b0;
      push((me_in && i > 0) ? a[i-1] : 1'b0, me_in && i == 0, ~me_in,
           {tag, " bit R3 R4 R5 R8"});
    end
    @(posedge clk);
    comp_drv = 1'b0;
    push(1'b0, me_in, ~me_in, {tag, " hold R7"});
  endtask

  // monitor: sample a quarter period after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_chk++;
        if ({sdata_oe, won, lost} !== {e.oe, e.won, e.lost}) begin
          n_fail++;
          $display("FAIL %s: actual oe/won/lost=%b%b%b expected=%b%b%b",
                   e.tag, sdata_oe, won, lost, e.oe, e.won, e.lost);
        end
      end else if (drv_done) begin
        summary();
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    n_chk++;  // R1 reset state
    if ({sdata_oe, won, lost} !== 3'b000) begin
      n_fail++;
      $display("FAIL R1 reset: actual oe/won/lost=%b%b%b expected=000", sdata_oe, won, lost);
    end
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    arb_run(4'hA, 1'b1, 1'b0, 4'h0, "alone A");
    arb_run(4'hF, 1'b1, 1'b1, 4'h3, "F vs 3");
    arb_run(4'h5, 1'b1, 1'b1, 4'h9, "5 vs 9 top-bit loss");
    arb_run(4'hC, 1'b1, 1'b1, 4'hD, "C vs D last-bit loss");
    arb_run(4'h9, 1'b1, 1'b1, 4'hB, "9 vs B mid loss");
    arb_run(4'h6, 1'b1, 1'b1, 4'h6, "tie 6 R8");
    arb_run(4'hE, 1'b0, 1'b1, 4'h2, "no part R6");
    arb_run(4'h0, 1'b1, 1'b0, 4'h0, "alone 0");
    arb_run(4'h0, 1'b1, 1'b1, 4'h1, "0 vs 1");
    arb_run(4'h7, 1'b1, 1'b1, 4'h8, "7 vs 8");
    arb_run(4'h8, 1'b1, 1'b1, 4'h7, "8 vs 7");
    drv_done = 1'b1;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all requirements: actual=hung expected=finished");
      summary();
    end
  end
endmodule